// File: doc/BRIEF.md
# BCD Real-Time Clock Calendar

This block keeps wall-clock time and a calendar in packed BCD. It receives a single-cycle enable at 4096 Hz and turns it into a 100 Hz average tick with a fractional divider. The divider runs 41 input ticks per step for 24 steps and 40 input ticks for the 25th step, so each 1024-tick window yields exactly 25 hundredths. Each hundredth advances a carry chain of eight fields: hundredths, seconds, minutes, hours, day-of-week, date, month and year. The hours field runs in either 24-hour or 12-hour (AM/PM) form.

Software sets any field through a byte-wide write port. Reads never see the running counters directly. A capture strobe copies all eight fields into a shadow set, and the read port returns that copy. A multi-byte read therefore stays coherent while the clock keeps running. The surrounding bus logic raises the capture strobe on a bus START and when its register pointer wraps to field 0.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset, both the live fields and the shadow fields hold hundredths 00, seconds 00, minutes 00, hours 00 (24-hour form), day-of-week 01, date 01, month 01 and year 00. Field addresses are 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day-of-week, 5 date, 6 month, 7 year.
- R2: Counting from reset or from a hundredths write, the divider produces one hundredth step on the 41st `tick_4k` pulse for 24 steps, and on the 40th pulse for every 25th step. After 1023 pulses the hundredths field reads 24; after 1024 pulses it reads 25. Cycles without `tick_4k` do not count.
- R3: Hundredths wrap from 99 to 00 and carry into seconds. Seconds and minutes each wrap from 59 to 00 and carry into the next field.
- R4: In 24-hour form (hours bit 6 = 0, bit 5 = tens bit of 20-23), hour 23 wraps to 00 and carries one day.
- R5: In 12-hour form (hours bit 6 = 1, bit 5 = PM), the hour sequence is 11 AM → 12 PM → 1 PM, and 11 PM → 12 AM. The PM bit toggles on entry to 12. Only the 11 PM → 12 AM step carries a day, and bit 6 is kept.
- R6: A day carry advances day-of-week, and day-of-week wraps from 7 to 1.
- R7: A day carry advances the date. The date wraps to 01 after 30 in months 04, 06, 09 and 11, after 28 in February of non-leap years, after 29 in February of years divisible by 4 (year 00 included), and after 31 otherwise. A date wrap advances the month. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R8: A write loads its field (masked to the field width) at the next clock edge. A write to hundredths also restarts the divider at the start of a 41-tick step.
- R9: `cap_stb` copies all live fields into the shadow set at the next edge. `rd_data` returns the shadow field at `rd_addr`, and it does not change without another strobe while the live time advances.
- R10: Written values are not range-checked. Counting continues from the written value, so seconds written as 75 step to 76.
- R11: When a write and a hundredth step fall on the same cycle, the write takes effect and that step is lost for the whole chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_4k | input | 1 | One-cycle enable at 4096 Hz |
| cap_stb | input | 1 | Copies live time into the shadow set |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 3 | Field written (0 = hundredths … 7 = year) |
| wr_data | input | 8 | BCD value to write |
| rd_addr | input | 3 | Shadow field selected for reading |
| rd_data | output | 8 | Shadow field contents |
| cent_tick | output | 1 | Pulses on each hundredth step |

## Verification
The assertions check the following on every cycle:
- Each hundredth step comes exactly 40 or 41 input ticks after the previous step or after a divider restart.
- The live time holds still unless a step or a write occurs.
- The shadow set equals the live time captured on the strobe, and stays stable otherwise.
- The 12/24-hour mode bit changes only through a write to the hours field.

Calendar values need the bench's directed scenarios:
- month lengths and leap years
- the 12-hour AM/PM sequence
- day-of-week wrap
- the exact 1023/1024 divider boundary
- the write-versus-step collision

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   localparam int NFIELD = 8;
   localparam int ADDR_W = $clog2(NFIELD);

   localparam int F_HUND = 0;
   localparam int F_SEC  = 1;
   localparam int F_MIN  = 2;
   localparam int F_HOUR = 3;
   localparam int F_DOW  = 4;
   localparam int F_DATE = 5;
   localparam int F_MON  = 6;
   localparam int F_YEAR = 7;

   typedef logic [7:0] bcd_t;
   typedef bcd_t [NFIELD-1:0] tvec_t;

   // Two-digit BCD increment; a low digit of 9 or more carries into the tens digit.
   function automatic bcd_t bcd_inc(bcd_t v);
      bcd_t r;
      if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
      else                r = {v[7:4], v[3:0] + 4'd1};
      return r;
   endfunction

   // Bits that each field stores; the others read as zero.
   function automatic bcd_t field_mask(int idx);
      case (idx)
         F_SEC, F_MIN, F_HOUR: return 8'h7F;
         F_DOW:                return 8'h07;
         F_DATE:               return 8'h3F;
         F_MON:                return 8'h1F;
         default:              return 8'hFF;
      endcase
   endfunction

   function automatic logic is_leap(bcd_t yr);
      int val;
      val = int'(yr[7:4]) * 10 + int'(yr[3:0]);
      return (val % 4) == 0;
   endfunction

   function automatic bcd_t month_end(bcd_t mon, bcd_t yr);
      case (mon)
         8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

   function automatic tvec_t init_time();
      tvec_t t;
      t         = '0;
      t[F_DOW]  = 8'h01;
      t[F_DATE] = 8'h01;
      t[F_MON]  = 8'h01;
      return t;
   endfunction

endpackage

// File: rtl/rtc_frac_div.sv
module rtc_frac_div #(
   parameter int DIV_HI  = 41,
   parameter int DIV_LO  = 40,
   parameter int HI_RUNS = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_in,
   input  logic clr,
   output logic pulse
);
   localparam int CNT_W = $clog2(DIV_HI);
   localparam int PH_W  = $clog2(HI_RUNS + 1);

   if (DIV_LO < 2 || DIV_LO > DIV_HI) begin : g_bad_ratio
      $error("rtc_frac_div: DIV_LO must lie in 2..DIV_HI");
   end
   if (HI_RUNS < 1) begin : g_bad_runs
      $error("rtc_frac_div: HI_RUNS must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim;

   if (DIV_LO == DIV_HI) begin : g_plain
      // Integer ratio: no phase sequencing needed.
      assign lim = CNT_W'(DIV_HI - 1);
   end else begin : g_frac
      logic [PH_W-1:0] ph_q;
      assign lim = (ph_q == PH_W'(HI_RUNS)) ? CNT_W'(DIV_LO - 1) : CNT_W'(DIV_HI - 1);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                ph_q <= '0;
         else if (clr)              ph_q <= '0;
         else if (tick_in && cnt_q == lim)
            ph_q <= (ph_q == PH_W'(HI_RUNS)) ? '0 : ph_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clr)     cnt_q <= '0;
      else if (tick_in) cnt_q <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
   end

   assign pulse = tick_in && !clr && (cnt_q == lim);

endmodule

// File: rtl/rtc_count_chain.sv
module rtc_count_chain
   import rtc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  bcd_t              wr_data,
   output tvec_t             t_q
);
   tvec_t t_d;
   bcd_t  hr_n;
   bcd_t  last_d;
   logic  c_sec, c_min, c_hr, c_day, c_mon, c_yr, day_roll;

   always_comb begin
      t_d      = t_q;
      hr_n     = t_q[F_HOUR];
      day_roll = 1'b0;
      last_d   = month_end(t_q[F_MON], t_q[F_YEAR]);

      c_sec = (t_q[F_HUND] == 8'h99);
      t_d[F_HUND] = c_sec ? 8'h00 : bcd_inc(t_q[F_HUND]);

      c_min = c_sec && (t_q[F_SEC] == 8'h59);
      if (c_sec) t_d[F_SEC] = (t_q[F_SEC] == 8'h59) ? 8'h00 : bcd_inc(t_q[F_SEC]);

      c_hr = c_min && (t_q[F_MIN] == 8'h59);
      if (c_min) t_d[F_MIN] = (t_q[F_MIN] == 8'h59) ? 8'h00 : bcd_inc(t_q[F_MIN]);

      if (t_q[F_HOUR][6]) begin
         // 12-hour form: 11 -> 12 flips PM; leaving 11 PM ends the day.
         if (t_q[F_HOUR][4:0] == 5'h11) begin
            hr_n     = {2'b01, ~t_q[F_HOUR][5], 5'h12};
            day_roll = t_q[F_HOUR][5];
         end else if (t_q[F_HOUR][4:0] == 5'h12) begin
            hr_n = {2'b01, t_q[F_HOUR][5], 5'h01};
         end else begin
            hr_n = bcd_inc(t_q[F_HOUR]);
         end
      end else begin
         if (t_q[F_HOUR][5:0] == 6'h23) begin
            hr_n     = 8'h00;
            day_roll = 1'b1;
         end else begin
            hr_n = bcd_inc(t_q[F_HOUR]);
         end
      end

      c_day = c_hr && day_roll;
      if (c_hr) t_d[F_HOUR] = hr_n;

      if (c_day) t_d[F_DOW] = (t_q[F_DOW] == 8'h07) ? 8'h01 : bcd_inc(t_q[F_DOW]);

      c_mon = c_day && (t_q[F_DATE] == last_d);
      if (c_day) t_d[F_DATE] = (t_q[F_DATE] == last_d) ? 8'h01 : bcd_inc(t_q[F_DATE]);

      c_yr = c_mon && (t_q[F_MON] == 8'h12);
      if (c_mon) t_d[F_MON] = (t_q[F_MON] == 8'h12) ? 8'h01 : bcd_inc(t_q[F_MON]);

      if (c_yr) t_d[F_YEAR] = (t_q[F_YEAR] == 8'h99) ? 8'h00 : bcd_inc(t_q[F_YEAR]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     t_q <= init_time();
      else if (wr_en) t_q[wr_addr] <= wr_data & field_mask(int'(wr_addr));
      else if (adv)   t_q <= t_d;
   end

endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow
   import rtc_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  cap,
   input  tvec_t live,
   output tvec_t snap
);
   for (genvar i = 0; i < NFIELD; i++) begin : g_fld
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   snap[i] <= init_time()[i];
         else if (cap) snap[i] <= live[i];
      end
   end

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
   import rtc_pkg::*;
#(
   parameter int DIV_HI  = 41,
   parameter int DIV_LO  = 40,
   parameter int HI_RUNS = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_4k,
   input  logic              cap_stb,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic              cent_tick
);
   tvec_t live_t;
   tvec_t shad_t;
   logic  hund_wr;

   assign hund_wr = wr_en && (wr_addr == ADDR_W'(F_HUND));

   rtc_frac_div #(
      .DIV_HI (DIV_HI),
      .DIV_LO (DIV_LO),
      .HI_RUNS(HI_RUNS)
   ) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_in(tick_4k),
      .clr    (hund_wr),
      .pulse  (cent_tick)
   );

   rtc_count_chain u_chain (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (cent_tick),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .t_q    (live_t)
   );

   rtc_shadow u_shad (
      .clk  (clk),
      .rst_n(rst_n),
      .cap  (cap_stb),
      .live (live_t),
      .snap (shad_t)
   );

   assign rd_data = shad_t[rd_addr];

endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk
   import rtc_pkg::*;
#(
   parameter int DIV_HI = 41,
   parameter int DIV_LO = 40
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_4k,
   input logic              cent_tick,
   input logic              cap_stb,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input tvec_t             live,
   input tvec_t             shadow
);
   localparam int SW = $clog2(DIV_HI + 1);

   logic [SW-1:0] seen_q;
   logic          hund_wr;

   assign hund_wr = wr_en && (wr_addr == ADDR_W'(F_HUND));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    seen_q <= '0;
      else if (hund_wr || cent_tick) seen_q <= '0;
      else if (tick_4k)              seen_q <= seen_q + 1'b1;
   end

   // R2
   step_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cent_tick |-> (seen_q == SW'(DIV_HI - 1) || seen_q == SW'(DIV_LO - 1)));

   // R2
   step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q < SW'(DIV_HI));

   // R8
   time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cent_tick && !wr_en) |=> $stable(live));

   // R9
   snap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_stb |=> (shadow == $past(live)));

   // R9
   snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_stb |=> $stable(shadow));

   // R5
   mode_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == ADDR_W'(F_HOUR)) |=> $stable(live[F_HOUR][6]));

endmodule

bind bcd_rtc_core rtc_core_chk #(
   .DIV_HI(DIV_HI),
   .DIV_LO(DIV_LO)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick_4k  (tick_4k),
   .cent_tick(cent_tick),
   .cap_stb  (cap_stb),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .live     (live_t),
   .shadow   (shad_t)
);

// File: tb/bcd_rtc_core_test.sv
`timescale 1ns/1ps
module bcd_rtc_core_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_4k = 1'b0;
   logic       cap_stb = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       cent_tick;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   bcd_rtc_core uut (
      .clk(clk), .rst_n(rst_n), .tick_4k(tick_4k), .cap_stb(cap_stb),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .cent_tick(cent_tick)
   );

   localparam int A_HUND = 0, A_SEC = 1, A_MIN = 2, A_HOUR = 3;
   localparam int A_DOW = 4, A_DATE = 5, A_MON = 6, A_YEAR = 7;

   task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic write_reg(int a, logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic ticks(int n);
      if (n > 0) begin
         @(negedge clk);
         tick_4k = 1'b1;
         repeat (n) @(negedge clk);
         tick_4k = 1'b0;
      end
   endtask

   task automatic capture();
      @(negedge clk);
      cap_stb = 1'b1;
      @(negedge clk);
      cap_stb = 1'b0;
   endtask

   task automatic peek(int a, output logic [7:0] v);
      rd_addr = 3'(a);
      #0.5 v = rd_data;
   endtask

   task automatic read_now(int a, output logic [7:0] v);
      capture();
      peek(a, v);
   endtask

   // Hundredths last so the divider starts a fresh 41-tick step.
   task automatic set_time(logic [7:0] hu, se, mi, ho, dw, dt, mo, yr);
      write_reg(A_SEC, se);  write_reg(A_MIN, mi);  write_reg(A_HOUR, ho);
      write_reg(A_DOW, dw);  write_reg(A_DATE, dt); write_reg(A_MON, mo);
      write_reg(A_YEAR, yr); write_reg(A_HUND, hu);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      logic [7:0] exp [8] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
      for (int i = 0; i < 8; i++) begin
         peek(i, v);
         check("R1", $sformatf("shadow field %0d", i), v, exp[i]);
      end
      capture();
      for (int i = 0; i < 8; i++) begin
         peek(i, v);
         check("R1", $sformatf("live field %0d", i), v, exp[i]);
      end
   endtask

   task automatic t_divider();
      logic [7:0] v;
      ticks(40);  read_now(A_HUND, v); check("R2", "40 ticks", v, 8'h00);
      ticks(1);   read_now(A_HUND, v); check("R2", "41 ticks", v, 8'h01);
      ticks(982); read_now(A_HUND, v); check("R2", "1023 ticks", v, 8'h24);
      ticks(1);   read_now(A_HUND, v); check("R2", "1024 ticks", v, 8'h25);
   endtask

   task automatic t_rollover();
      logic [7:0] v;
      set_time(8'h99, 8'h59, 8'h59, 8'h05, 8'h02, 8'h10, 8'h03, 8'h20);
      ticks(41);
      read_now(A_HUND, v); check("R3", "hundredths wrap", v, 8'h00);
      peek(A_SEC, v);      check("R3", "seconds wrap", v, 8'h00);
      peek(A_MIN, v);      check("R3", "minutes wrap", v, 8'h00);
      peek(A_HOUR, v);     check("R3", "hour carry", v, 8'h06);
      peek(A_DATE, v);     check("R3", "no day carry", v, 8'h10);
   endtask

   task automatic t_midnight24();
      logic [7:0] v;
      set_time(8'h99, 8'h59, 8'h59, 8'h23, 8'h03, 8'h15, 8'h06, 8'h24);
      ticks(41);
      read_now(A_HOUR, v); check("R4", "23 -> 00", v, 8'h00);
      peek(A_DOW, v);      check("R4", "dow carry", v, 8'h04);
      peek(A_DATE, v);     check("R4", "date carry", v, 8'h16);
      set_time(8'h99, 8'h59, 8'h59, 8'h19, 8'h03, 8'h15, 8'h06, 8'h24);
      ticks(41);
      read_now(A_HOUR, v); check("R4", "19 -> 20", v, 8'h20);
   endtask

   task automatic t_twelve();
      logic [7:0] v;
      set_time(8'h99, 8'h59, 8'h59, 8'h51, 8'h02, 8'h07, 8'h05, 8'h22);
      ticks(41);
      read_now(A_HOUR, v); check("R5", "11AM -> 12PM", v, 8'h72);
      peek(A_DATE, v);     check("R5", "noon no day carry", v, 8'h07);
      set_time(8'h99, 8'h59, 8'h59, 8'h72, 8'h02, 8'h07, 8'h05, 8'h22);
      ticks(41);
      read_now(A_HOUR, v); check("R5", "12PM -> 1PM", v, 8'h61);
      set_time(8'h99, 8'h59, 8'h59, 8'h49, 8'h02, 8'h07, 8'h05, 8'h22);
      ticks(41);
      read_now(A_HOUR, v); check("R5", "9AM -> 10AM", v, 8'h50);
      set_time(8'h99, 8'h59, 8'h59, 8'h71, 8'h02, 8'h07, 8'h05, 8'h22);
      ticks(41);
      read_now(A_HOUR, v); check("R5", "11PM -> 12AM", v, 8'h52);
      peek(A_DATE, v);     check("R5", "midnight day carry", v, 8'h08);
   endtask

   task automatic t_dow();
      logic [7:0] v;
      set_time(8'h99, 8'h59, 8'h59, 8'h23, 8'h07, 8'h01, 8'h01, 8'h30);
      ticks(41);
      read_now(A_DOW, v); check("R6", "dow 7 -> 1", v, 8'h01);
   endtask

   task automatic day_step(logic [7:0] dt, mo, yr, exp_dt, exp_mo, exp_yr, string what);
      logic [7:0] v;
      set_time(8'h99, 8'h59, 8'h59, 8'h23, 8'h01, dt, mo, yr);
      ticks(41);
      read_now(A_DATE, v); check("R7", {what, " date"}, v, exp_dt);
      peek(A_MON, v);      check("R7", {what, " month"}, v, exp_mo);
      peek(A_YEAR, v);     check("R7", {what, " year"}, v, exp_yr);
   endtask

   task automatic t_calendar();
      day_step(8'h30, 8'h04, 8'h21, 8'h01, 8'h05, 8'h21, "Apr 30");
      day_step(8'h30, 8'h01, 8'h21, 8'h31, 8'h01, 8'h21, "Jan 30");
      day_step(8'h28, 8'h02, 8'h23, 8'h01, 8'h03, 8'h23, "Feb 28 plain");
      day_step(8'h28, 8'h02, 8'h24, 8'h29, 8'h02, 8'h24, "Feb 28 leap");
      day_step(8'h29, 8'h02, 8'h24, 8'h01, 8'h03, 8'h24, "Feb 29 leap");
      day_step(8'h28, 8'h02, 8'h00, 8'h29, 8'h02, 8'h00, "Feb 28 year 00");
      day_step(8'h31, 8'h12, 8'h99, 8'h01, 8'h01, 8'h00, "Dec 31 year 99");
   endtask

   task automatic t_write();
      logic [7:0] v;
      write_reg(A_MIN, 8'h42);
      read_now(A_MIN, v); check("R8", "minute write", v, 8'h42);
      write_reg(A_DATE, 8'hFF);
      read_now(A_DATE, v); check("R8", "date write masked", v, 8'h3F);
      write_reg(A_DATE, 8'h12);
      ticks(20);
      write_reg(A_HUND, 8'h10);
      ticks(40); read_now(A_HUND, v); check("R8", "restart 40 ticks", v, 8'h10);
      ticks(1);  read_now(A_HUND, v); check("R8", "restart 41 ticks", v, 8'h11);
   endtask

   task automatic t_shadow();
      logic [7:0] v;
      set_time(8'h05, 8'h11, 8'h22, 8'h08, 8'h01, 8'h02, 8'h03, 8'h04);
      capture();
      ticks(41);
      write_reg(A_SEC, 8'h33);
      peek(A_HUND, v); check("R9", "stale hundredths", v, 8'h05);
      peek(A_SEC, v);  check("R9", "stale seconds", v, 8'h11);
      capture();
      peek(A_HUND, v); check("R9", "fresh hundredths", v, 8'h06);
      peek(A_SEC, v);  check("R9", "fresh seconds", v, 8'h33);
   endtask

   task automatic t_illegal();
      logic [7:0] v;
      set_time(8'h99, 8'h75, 8'h10, 8'h10, 8'h01, 8'h01, 8'h01, 8'h01);
      ticks(41);
      read_now(A_SEC, v); check("R10", "seconds 75 -> 76", v, 8'h76);
   endtask

   task automatic t_collide();
      logic [7:0] v;
      set_time(8'h50, 8'h00, 8'h00, 8'h10, 8'h01, 8'h01, 8'h01, 8'h01);
      ticks(40);
      @(negedge clk);
      tick_4k = 1'b1; wr_en = 1'b1; wr_addr = 3'(A_SEC); wr_data = 8'h10;
      @(negedge clk);
      tick_4k = 1'b0; wr_en = 1'b0;
      read_now(A_HUND, v); check("R11", "step dropped", v, 8'h50);
      peek(A_SEC, v);      check("R11", "write kept", v, 8'h10);
      ticks(41);
      read_now(A_HUND, v); check("R11", "next step", v, 8'h51);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_divider();
      t_rollover();
      t_midnight24();
      t_twelve();
      t_dow();
      t_calendar();
      t_write();
      t_shadow();
      t_illegal();
      t_collide();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule